// File: doc/BRIEF.md
# Programmable Spill Gate Generator

This block drives the spill gate, the interval in which beam-related triggers and scalers are allowed to run. A spill can be requested from three places: a free-running internal repeat timer, an external spill level, or a software request bit. All timing is counted in millisecond ticks, which arrive as a one-clock pulse on `msTick`. The register decoding lives elsewhere, so every control field reaches the block as a plain input.

The external and software requests run in one of two modes. In gate mode the request level is passed straight to the gate. In timed mode a rising request edge opens a sequence: the block waits a programmed number of ticks, then holds the gate open for a programmed number of ticks. The internal timer always uses the timed sequence and issues one start every repeat interval. Whenever the gate opens, a one-clock start strobe is emitted with it.

Top module: `spill_gate_gen`

## Requirements
- R1: After reset `spillGate` and `spillStart` are 0.
- R2: With `gateMode`=1, `spillGate` equals (`extEnable` AND `extSpillIn`) OR `softSpill`, taken one clock after those inputs are sampled.
- R3: With `extEnable`=0 the level on `extSpillIn` has no effect on `spillGate` in either mode.
- R4: With `gateMode`=0, a rising edge of the request level (enabled external input OR software bit) starts a sequence. The gate rises on the `delayMs`-th following tick and falls on the `durationMs`-th tick after that. A held level does not retrigger and a falling edge has no effect.
- R5: With `delayMs`=0 a timed start opens the gate in the clock that follows the start event.
- R6: With `durationMs`=0 a start event never opens the gate and never produces a strobe.
- R7: While `timerEnable`=1 and `repeatMs`>0, a start event occurs on every `repeatMs`-th tick, counted from when the timer was enabled. Each event runs the same delay and duration sequence. With `repeatMs`=0 the timer produces no events.
- R8: A start event from any source that arrives while a delay or a spill is in progress is ignored. This includes a timer event on the tick that closes the spill.
- R9: `spillStart` is high for exactly one clock on every rising edge of `spillGate`, in the first clock the gate is high.
- R10: When `extEnable`, `timerEnable` and `softSpill` are all 0, the gate falls on the next clock, the sequence returns to idle, and the repeat timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-clock pulse per millisecond |
| extSpillIn | input | 1 | External spill request level |
| extEnable | input | 1 | Enables the external request |
| timerEnable | input | 1 | Enables the internal repeat timer |
| softSpill | input | 1 | Software spill request level |
| gateMode | input | 1 | 1: request level is the gate; 0: request edge starts a timed spill |
| delayMs | input | DLY_W (16) | Ticks from start event to gate open |
| repeatMs | input | REP_W (16) | Ticks between internal timer events |
| durationMs | input | DUR_W (31) | Ticks the gate stays open in a timed spill |
| spillGate | output | 1 | Spill gate |
| spillStart | output | 1 | One-clock strobe on each gate rise |

## Verification
The bench builds the block with its default field widths of 16, 16 and 31 bits, so the counter and compare logic has the same size as in use. Instead of a real 1 ms tick period it drives `msTick` every other clock and programs delay, repeat and duration values of zero to three ticks. This keeps wrap points reachable in a few dozen clocks: the repeat wrap landing on the tick that closes a spill, a zero delay, a zero duration and a zero repeat interval. Re-enabling the timer after all sources are cleared shows from the gate timing that the repeat count restarted from zero.

// File: rtl/spill_gate_pkg.sv
package spill_gate_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WAIT  = 2'd1,
    SEQ_SPILL = 2'd2
  } seq_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic phaseClr;   // zero the phase counter
    logic phaseRun;   // count ticks in the current phase
    logic selDur;     // 1: compare against duration, 0: against delay
    logic repClr;     // hold the repeat timer at zero
  } spill_strobe_t;

endpackage

// File: rtl/spill_gate_dp.sv
module spill_gate_dp
  import spill_gate_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int REP_W = 16,
  parameter int DUR_W = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  logic [DLY_W-1:0]   delayMs,
  input  logic [REP_W-1:0]   repeatMs,
  input  logic [DUR_W-1:0]   durationMs,
  input  spill_strobe_t      strobe,
  output logic               phaseHit,
  output logic               repHit
);

  localparam int PW = DUR_W + 1;
  localparam int RW = REP_W + 1;

  logic [DUR_W-1:0] phaseCnt;
  logic [REP_W-1:0] repCnt;
  logic [DUR_W-1:0] phaseTarget;
  logic             repWrap;

  assign phaseTarget = strobe.selDur ? durationMs : DUR_W'(delayMs);

  // A phase ends on the tick that brings the count up to its target
  assign phaseHit = strobe.phaseRun && msTick &&
                    ((PW'(phaseCnt) + PW'(1)) >= PW'(phaseTarget));

  always_ff @(posedge clk) begin
    if (!rstN || strobe.phaseClr) begin
      phaseCnt <= '0;
    end else if (strobe.phaseRun && msTick) begin
      phaseCnt <= phaseCnt + DUR_W'(1);
    end
  end

  // Repeat timer: counts ticks and wraps every repeatMs ticks
  assign repWrap = (RW'(repCnt) + RW'(1)) >= RW'(repeatMs);
  assign repHit  = msTick && !strobe.repClr && repWrap && (repeatMs != '0);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.repClr) begin
      repCnt <= '0;
    end else if (msTick) begin
      repCnt <= repWrap ? '0 : repCnt + REP_W'(1);
    end
  end

  // R7: while the repeat interval is held, the count stays below it
  p_rep_in_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    (repeatMs != '0 && $stable(repeatMs) && !strobe.repClr && $past(repCnt) < repeatMs)
      |-> repCnt < repeatMs);

endmodule

// File: rtl/spill_gate_ctrl.sv
module spill_gate_ctrl
  import spill_gate_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int DUR_W = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extSpillIn,
  input  logic               extEnable,
  input  logic               timerEnable,
  input  logic               softSpill,
  input  logic               gateMode,
  input  logic [DLY_W-1:0]   delayMs,
  input  logic [DUR_W-1:0]   durationMs,
  input  logic               phaseHit,
  input  logic               repHit,
  output spill_strobe_t      strobe,
  output logic               spillGate,
  output logic               spillStart
);

  seq_state_t stateQ, stateD;
  logic reqPrevQ, gateQ, startQ;
  logic reqLvl, reqRise, startEv, allOff, gateD;

  assign allOff  = !extEnable && !timerEnable && !softSpill;
  assign reqLvl  = (extEnable && extSpillIn) || softSpill;
  assign reqRise = reqLvl && !reqPrevQ;
  assign startEv = (!gateMode && reqRise) || repHit;

  always_comb begin
    stateD          = stateQ;
    strobe.phaseClr = 1'b0;
    strobe.phaseRun = 1'b0;
    strobe.selDur   = (stateQ == SEQ_SPILL);
    strobe.repClr   = !timerEnable;
    if (allOff) begin
      stateD          = SEQ_IDLE;
      strobe.phaseClr = 1'b1;
      strobe.repClr   = 1'b1;
    end else begin
      unique case (stateQ)
        SEQ_IDLE: begin
          if (startEv) begin
            strobe.phaseClr = 1'b1;
            if (delayMs != '0)         stateD = SEQ_WAIT;
            else if (durationMs != '0) stateD = SEQ_SPILL;
          end
        end
        SEQ_WAIT: begin
          strobe.phaseRun = 1'b1;
          if (phaseHit) begin
            strobe.phaseClr = 1'b1;
            stateD = (durationMs != '0) ? SEQ_SPILL : SEQ_IDLE;
          end
        end
        SEQ_SPILL: begin
          strobe.phaseRun = 1'b1;
          if (phaseHit) begin
            strobe.phaseClr = 1'b1;
            stateD = SEQ_IDLE;
          end
        end
        default: stateD = SEQ_IDLE;
      endcase
    end
  end

  assign gateD = !allOff && ((stateD == SEQ_SPILL) || (gateMode && reqLvl));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= SEQ_IDLE;
      reqPrevQ <= 1'b0;
      gateQ    <= 1'b0;
      startQ   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      reqPrevQ <= reqLvl;
      gateQ    <= gateD;
      startQ   <= gateD && !gateQ;
    end
  end

  assign spillGate  = gateQ;
  assign spillStart = startQ;

  // R9: strobe only together with a fresh gate, and every fresh gate has one
  p_strobe_on_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateQ) |-> startQ);
  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ);

  // R10: all sources off closes the gate on the next clock
  p_all_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    allOff |=> !gateQ);

  // R2: gate mode passes an active request level
  p_gate_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    (gateMode && reqLvl && !allOff) |=> gateQ);

  // R8: a running spill stays in place until its phase ends
  p_spill_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_SPILL && !allOff && !phaseHit) |=> stateQ == SEQ_SPILL);

  // R6: zero duration never reaches the spill phase from idle
  p_zero_dur_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_IDLE && durationMs == '0) |=> stateQ != SEQ_SPILL);

endmodule

// File: rtl/spill_gate_gen.sv
module spill_gate_gen
  import spill_gate_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int REP_W = 16,
  parameter int DUR_W = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msTick,
  input  logic               extSpillIn,
  input  logic               extEnable,
  input  logic               timerEnable,
  input  logic               softSpill,
  input  logic               gateMode,
  input  logic [DLY_W-1:0]   delayMs,
  input  logic [REP_W-1:0]   repeatMs,
  input  logic [DUR_W-1:0]   durationMs,
  output logic               spillGate,
  output logic               spillStart
);

  spill_strobe_t strobe;
  logic phaseHit, repHit;

  spill_gate_ctrl #(.DLY_W(DLY_W), .DUR_W(DUR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .extSpillIn(extSpillIn), .extEnable(extEnable),
    .timerEnable(timerEnable), .softSpill(softSpill), .gateMode(gateMode),
    .delayMs(delayMs), .durationMs(durationMs),
    .phaseHit(phaseHit), .repHit(repHit),
    .strobe(strobe), .spillGate(spillGate), .spillStart(spillStart)
  );

  spill_gate_dp #(.DLY_W(DLY_W), .REP_W(REP_W), .DUR_W(DUR_W)) dp_i (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .delayMs(delayMs), .repeatMs(repeatMs), .durationMs(durationMs),
    .strobe(strobe), .phaseHit(phaseHit), .repHit(repHit)
  );

endmodule

// File: tb/spill_gate_gen_tb.sv
module spill_gate_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msTick = 1'b0;
  logic        extSpillIn = 1'b0, extEnable = 1'b0, timerEnable = 1'b0;
  logic        softSpill = 1'b0, gateMode = 1'b0;
  logic [15:0] delayMs = '0, repeatMs = '0;
  logic [30:0] durationMs = '0;
  logic        spillGate, spillStart;

  int applied = 0;
  int errors  = 0;
  int startSeen = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  spill_gate_gen dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick),
    .extSpillIn(extSpillIn), .extEnable(extEnable), .timerEnable(timerEnable),
    .softSpill(softSpill), .gateMode(gateMode),
    .delayMs(delayMs), .repeatMs(repeatMs), .durationMs(durationMs),
    .spillGate(spillGate), .spillStart(spillStart)
  );

  always @(negedge clk) if (rstN && spillStart) startSeen++;

  typedef struct packed {
    logic       m, e, i, s, t;     // gateMode, extEnable, extSpillIn, softSpill, timerEnable
    logic [7:0] d, r, u;           // delay, repeat, duration
    logic [3:0] k;                 // ticks after settling
    logic       g;                 // expected gate
    logic [7:0] st;                // expected cumulative starts
    logic [7:0] req;               // requirement number for messages
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 8'd0,8'd0,8'd0, 4'd0, 1'b1, 8'd1, 8'd2},  // R2 ext level
    '{1'b1,1'b1,1'b0,1'b0,1'b0, 8'd0,8'd0,8'd0, 4'd0, 1'b0, 8'd1, 8'd2},  // R2
    '{1'b1,1'b0,1'b1,1'b0,1'b1, 8'd0,8'd0,8'd0, 4'd0, 1'b0, 8'd1, 8'd3},  // R3 ext disabled
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 8'd0,8'd0,8'd0, 4'd0, 1'b1, 8'd2, 8'd2},  // R2 soft level
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 8'd0,8'd0,8'd0, 4'd0, 1'b0, 8'd2, 8'd2},  // R2
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,8'd0,8'd3, 4'd1, 1'b0, 8'd2, 8'd4},  // R4 in delay
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,8'd0,8'd3, 4'd1, 1'b1, 8'd3, 8'd9},  // R4 R9 gate opens
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,8'd0,8'd3, 4'd2, 1'b1, 8'd3, 8'd4},  // R4
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 8'd2,8'd0,8'd3, 4'd1, 1'b0, 8'd3, 8'd4},  // R4 closes, held level
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd2,8'd0,8'd3, 4'd0, 1'b0, 8'd3, 8'd4},  // R4
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 8'd0,8'd0,8'd2, 4'd0, 1'b1, 8'd4, 8'd5},  // R5 zero delay
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 8'd0,8'd0,8'd2, 4'd1, 1'b1, 8'd4, 8'd4},  // R4 falling edge
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 8'd0,8'd0,8'd2, 4'd1, 1'b0, 8'd4, 8'd8},  // R8 rise in spill
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 8'd0,8'd0,8'd2, 4'd2, 1'b0, 8'd4, 8'd8},  // R8
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd3, 1'b0, 8'd4, 8'd7},  // R7 timer event
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd1, 1'b1, 8'd5, 8'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd1, 1'b1, 8'd5, 8'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd1, 1'b0, 8'd5, 8'd8},  // R8 event at spill end
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd3, 1'b0, 8'd5, 8'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd1, 1'b1, 8'd6, 8'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,8'd3,8'd2, 4'd0, 1'b0, 8'd6, 8'd10}, // R10 clear mid-spill
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd3, 1'b0, 8'd6, 8'd10}, // R10 timer restarted
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 8'd1,8'd3,8'd2, 4'd1, 1'b1, 8'd7, 8'd7}   // R7
  };

  task automatic msStep();
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
  endtask

  task automatic checkBit(string tag, logic act, logic exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkInt(string tag, int act, int exp);
    applied++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setAll(logic m, logic e, logic i, logic s, logic t,
                        int d, int r, int u);
    @(negedge clk);
    gateMode = m; extEnable = e; extSpillIn = i; softSpill = s; timerEnable = t;
    delayMs = 16'(d); repeatMs = 16'(r); durationMs = 31'(u);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    checkBit("R1 gate after reset", spillGate, 1'b0);
    checkBit("R1 strobe after reset", spillStart, 1'b0);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VEC[n];
      setAll(v.m, v.e, v.i, v.s, v.t, int'(v.d), int'(v.r), int'(v.u));
      for (int k = 0; k < int'(v.k); k++) msStep();
      #1;
      checkBit($sformatf("R%0d row %0d gate", v.req, n), spillGate, v.g);
      checkInt($sformatf("R9 row %0d start count", n), startSeen, int'(v.st));
    end

    // R6: zero duration never opens the gate
    setAll(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 0);
    base = startSeen;
    setAll(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, 0, 0);
    for (int k = 0; k < 3; k++) msStep();
    #1;
    checkBit("R6 zero duration gate", spillGate, 1'b0);
    checkInt("R6 zero duration starts", startSeen, base);

    // R4/R3: timed start from the external input
    setAll(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0, 1);
    setAll(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 0, 0, 1);
    #1;
    checkBit("R4 ext timed open", spillGate, 1'b1);
    msStep(); #1;
    checkBit("R4 ext timed close", spillGate, 1'b0);

    // R3: disabled external input gives no edge in timed mode
    setAll(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 1);
    base = startSeen;
    @(negedge clk) extSpillIn = 1'b1;
    msStep(); msStep(); #1;
    checkBit("R3 disabled ext timed", spillGate, 1'b0);
    checkInt("R3 disabled ext starts", startSeen, base);

    // R7: zero repeat interval gives no timer events
    setAll(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 1);
    base = startSeen;
    for (int k = 0; k < 6; k++) msStep();
    #1;
    checkInt("R7 zero repeat starts", startSeen, base);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule